// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the system reset for a digital subsystem from two sources: a supply-good flag that has already been qualified and synchronized, and a raw active-low manual request coming straight from a push button or another logic output. The manual request is brought into the clock domain through a two-flop synchronizer. It is then debounced, so contact bounce shorter than a configurable window never reaches the reset logic.

Reset is held while the supply flag is low or the debounced manual request is active. Once both causes have gone away, reset is held for a further, fixed number of time-base ticks. If either cause comes back during that hold, the count starts again. A single-cycle tick input sets the time base; with a 1 ms tick, the defaults give a 20 ms debounce window and a 200 ms stretch. The block drives an active-low reset and its active-high complement. A watchdog can force a reset only by driving the manual input.

Top module: `rst_pulse_gen`

## Requirements
- R1: While the logic reset `por_n` is low, `rst_out_n` is 0. After `por_n` rises with no cause present, `rst_out_n` rises at the clock edge that samples the STRETCH_TICKS-th tick.
- R2: When `supply_ok` is 0 at a clock edge, `rst_out_n` is 0 after that edge, and it stays 0 for as long as `supply_ok` stays 0.
- R3: `mr_raw_n` passes through two synchronizer flops. A new level is accepted only after it has been sampled at DEBOUNCE_TICKS consecutive ticks. A pulse shorter than that has no effect on `rst_out_n`.
- R4: An accepted low level on the manual input drives `rst_out_n` to 0 one clock after acceptance, and holds it at 0 while the accepted level stays low.
- R5: Once the last cause clears, `rst_out_n` rises at the clock edge that samples exactly the STRETCH_TICKS-th tick after that point.
- R6: If a cause reappears while the stretch is running, the tick count is cleared, and a full STRETCH_TICKS stretch follows when the cause clears again.
- R7: `rst_out` is at all times the inverse of `rst_out_n`.
- R8: Time advances only on clock edges where `tick` is 1. Without ticks, a pending stretch never ends and `rst_out_n` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous active-low logic reset (power-up of the logic) |
| tick | input | 1 | One-cycle time-base enable |
| supply_ok | input | 1 | Synchronized supply-good flag, 1 when the supply is above its threshold |
| mr_raw_n | input | 1 | Raw active-low manual reset request, may bounce |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset, complement of rst_out_n |

## Verification
The bound checker runs on every cycle and covers four things. It confirms that the two outputs are complementary. It confirms that a low supply flag or an accepted manual press forces reset on the next edge. It confirms that reset is released only on a tick edge with the supply good, and that the debounced level changes only on a tick. A tick counter in the checker bounds the stretch and requires its exact length at each release. The directed scenarios are needed for the rest: the end-to-end latency from a raw button edge through the synchronizer and debounce window, the rejection of bursts of short bounces, the restart of the stretch by a brief supply dip, and the frozen hold when the tick stops.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

    // Phase of the post-release hold machine.
    typedef enum logic [1:0] {
        ST_CAUSE    = 2'd0,  // a reset cause is present
        ST_STRETCH  = 2'd1,  // causes gone, counting ticks
        ST_RELEASED = 2'd2   // reset deasserted
    } stretch_state_e;

    // Counter width that can hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    // Chain of STAGES flops; STAGES must be at least 2.
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rsg_debounce.sv
module rsg_debounce
    import rsg_pkg::*;
#(
    parameter int unsigned TICKS     = 20,
    parameter logic        RESET_LVL = 1'b1
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic level_in,
    output logic level_out
);
    localparam int unsigned CW = cnt_width(TICKS);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d = deb_q;
        if (level_in == deb_q.lvl) begin
            // Input agrees with the accepted level: forget any partial count.
            deb_d.cnt = '0;
        end else if (tick) begin
            if (deb_q.cnt == CW'(TICKS - 1)) begin
                deb_d.lvl = level_in;
                deb_d.cnt = '0;
            end else begin
                deb_d.cnt = deb_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            deb_q.lvl <= RESET_LVL;
            deb_q.cnt <= '0;
        end else begin
            deb_q <= deb_d;
        end
    end

    assign level_out = deb_q.lvl;
endmodule

// File: rtl/rsg_stretch.sv
module rsg_stretch
    import rsg_pkg::*;
#(
    parameter int unsigned TICKS = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic cause,
    output logic hold
);
    localparam int unsigned CW = cnt_width(TICKS);

    typedef struct packed {
        stretch_state_e st;
        logic [CW-1:0]  cnt;
    } str_t;

    str_t str_d, str_q;

    always_comb begin
        str_d = str_q;
        if (cause) begin
            str_d.st  = ST_CAUSE;
            str_d.cnt = '0;
        end else begin
            unique case (str_q.st)
                ST_CAUSE, ST_STRETCH: begin
                    str_d.st = ST_STRETCH;
                    if (tick) begin
                        if (str_q.cnt == CW'(TICKS - 1)) begin
                            str_d.st  = ST_RELEASED;
                            str_d.cnt = '0;
                        end else begin
                            str_d.cnt = str_q.cnt + 1'b1;
                        end
                    end
                end
                ST_RELEASED: begin
                    str_d.cnt = '0;
                end
                default: begin
                    str_d.st  = ST_CAUSE;
                    str_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            str_q.st  <= ST_STRETCH;
            str_q.cnt <= '0;
        end else begin
            str_q <= str_d;
        end
    end

    assign hold = (str_q.st != ST_RELEASED);
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned DEBOUNCE_TICKS = 20,
    parameter int unsigned STRETCH_TICKS  = 200
) (
    input  logic clk,
    input  logic por_n,
    input  logic tick,
    input  logic supply_ok,
    input  logic mr_raw_n,
    output logic rst_out_n,
    output logic rst_out
);
    logic mr_sync_n;
    logic mr_level;
    logic any_cause;
    logic hold;

    rsg_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (mr_raw_n),
        .dout  (mr_sync_n)
    );

    rsg_debounce #(
        .TICKS     (DEBOUNCE_TICKS),
        .RESET_LVL (1'b1)
    ) u_debounce (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .level_in  (mr_sync_n),
        .level_out (mr_level)
    );

    always_comb begin
        any_cause = !supply_ok || !mr_level;
    end

    rsg_stretch #(
        .TICKS (STRETCH_TICKS)
    ) u_stretch (
        .clk   (clk),
        .por_n (por_n),
        .tick  (tick),
        .cause (any_cause),
        .hold  (hold)
    );

    assign rst_out_n = !hold;
    assign rst_out   = hold;
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
    parameter int unsigned STRETCH_TICKS = 200
) (
    input logic clk,
    input logic por_n,
    input logic tick,
    input logic supply_ok,
    input logic mr_level,
    input logic rst_out_n,
    input logic rst_out
);
    // Ticks seen since the last cause, while reset is held.
    int unsigned seen_ticks;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                                 seen_ticks <= 0;
        else if (!supply_ok || !mr_level || rst_out_n) seen_ticks <= 0;
        else if (tick)                              seen_ticks <= seen_ticks + 1;
    end

    // R7: outputs complementary
    p_complement_r7: assert property (@(posedge clk) disable iff (!por_n)
        rst_out == !rst_out_n);

    // R2: low supply forces reset on the next edge
    p_supply_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
        !supply_ok |=> !rst_out_n);

    // R4: accepted manual press forces reset on the next edge
    p_manual_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        !mr_level |=> !rst_out_n);

    // R3: the accepted manual level changes only on a tick edge
    p_debounce_tick_r3: assert property (@(posedge clk) disable iff (!por_n)
        (mr_level != $past(mr_level)) |-> $past(tick));

    // R8: release only on a tick edge with the supply good
    p_release_on_tick_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> ($past(tick) && $past(supply_ok)));

    // R5: the stretch never runs past its length
    p_stretch_limit_r5: assert property (@(posedge clk) disable iff (!por_n)
        seen_ticks <= STRETCH_TICKS);

    // R5: release happens exactly at the last tick of the stretch
    p_stretch_exact_r5: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_out_n) |-> (seen_ticks == STRETCH_TICKS));
endmodule

bind rst_pulse_gen rsg_checker #(
    .STRETCH_TICKS (STRETCH_TICKS)
) u_rsg_checker (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .mr_level  (mr_level),
    .rst_out_n (rst_out_n),
    .rst_out   (rst_out)
);

// File: tb/rst_pulse_gen_test.sv
`timescale 1ns/1ps
module rst_pulse_gen_test;
    localparam int DEB     = 4;
    localparam int STRETCH = 10;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic tick = 1'b0;
    logic tick_en = 1'b1;
    logic supply_ok = 1'b1;
    logic mr_raw_n = 1'b1;
    logic rst_out_n, rst_out;

    int checks = 0;
    int errors = 0;
    int comp_bad = 0;
    logic [1:0] div = 2'd0;

    always #2.5 clk = ~clk;  // 200 MHz

    // Tick: one clock in four, changed on the falling edge.
    always @(negedge clk) begin
        div  = div + 2'd1;
        tick = tick_en && (div == 2'd0);
    end

    rst_pulse_gen #(
        .SYNC_STAGES    (2),
        .DEBOUNCE_TICKS (DEB),
        .STRETCH_TICKS  (STRETCH)
    ) uut (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .supply_ok (supply_ok),
        .mr_raw_n  (mr_raw_n),
        .rst_out_n (rst_out_n),
        .rst_out   (rst_out)
    );

    // R7 monitor, sampled away from the rising edge.
    always @(negedge clk) begin
        if (por_n && (rst_out !== !rst_out_n)) comp_bad++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Return to a falling edge just after a tick edge.
    task automatic align();
        do begin
            @(posedge clk); #1;
        end while (!tick);
        @(negedge clk);
    endtask

    // Count ticks at rising edges until rst_out_n reaches lvl; -1 on timeout.
    task automatic ticks_until(input logic lvl, input int maxc, output int n);
        n = 0;
        for (int i = 0; i < maxc; i++) begin
            @(posedge clk); #1;
            if (tick) n++;
            if (rst_out_n === lvl) return;
        end
        n = -1;
    endtask

    task automatic wait_clocks(input int c);
        for (int i = 0; i < c; i++) @(negedge clk);
    endtask

    task automatic t_power_up();
        int n;
        wait_clocks(3);
        check(rst_out_n === 1'b0, "R1 reset low during por", int'(rst_out_n), 0);
        check(rst_out === 1'b1, "R7 complement during por", int'(rst_out), 1);
        align();
        por_n = 1'b1;
        ticks_until(1'b1, 400, n);
        check(n == STRETCH, "R1 power-up stretch ticks", n, STRETCH);
    endtask

    task automatic t_supply();
        int n;
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(rst_out_n === 1'b0, "R2 assert one clock after supply drop", int'(rst_out_n), 0);
        wait_clocks(200);
        check(rst_out_n === 1'b0, "R2 held while supply low", int'(rst_out_n), 0);
        align();
        supply_ok = 1'b1;
        ticks_until(1'b1, 400, n);
        check(n == STRETCH, "R5 stretch after supply recovery", n, STRETCH);
    endtask

    task automatic t_manual();
        int n;
        align();
        mr_raw_n = 1'b0;
        ticks_until(1'b0, 400, n);
        check(n == DEB, "R3 R4 press accepted after debounce ticks", n, DEB);
        wait_clocks(200);
        check(rst_out_n === 1'b0, "R4 held while button low", int'(rst_out_n), 0);
        align();
        mr_raw_n = 1'b1;
        ticks_until(1'b1, 400, n);
        check(n == DEB + STRETCH, "R3 R5 release debounce plus stretch", n, DEB + STRETCH);
    endtask

    task automatic t_bounce();
        int low_seen = 0;
        for (int b = 0; b < 6; b++) begin
            mr_raw_n = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (rst_out_n !== 1'b1) low_seen++;
            end
            mr_raw_n = 1'b1;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (rst_out_n !== 1'b1) low_seen++;
            end
        end
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rst_out_n !== 1'b1) low_seen++;
        end
        check(low_seen == 0, "R3 short bounces ignored", low_seen, 0);
    endtask

    task automatic t_restart();
        int n;
        align();
        supply_ok = 1'b0;
        @(negedge clk);
        align();
        supply_ok = 1'b1;
        for (int k = 0; k < STRETCH / 2; k++) align();
        supply_ok = 1'b0;
        wait_clocks(2);
        check(rst_out_n === 1'b0, "R6 reset still held during restart", int'(rst_out_n), 0);
        align();
        supply_ok = 1'b1;
        ticks_until(1'b1, 400, n);
        check(n == STRETCH, "R6 full stretch after restart", n, STRETCH);
    endtask

    task automatic t_no_tick();
        int n;
        align();
        supply_ok = 1'b0;
        wait_clocks(2);
        tick_en = 1'b0;
        supply_ok = 1'b1;
        wait_clocks(150);
        check(rst_out_n === 1'b0, "R8 stretch frozen without ticks", int'(rst_out_n), 0);
        tick_en = 1'b1;
        align();
        ticks_until(1'b1, 400, n);
        // One tick already consumed by align().
        check(n == STRETCH - 1, "R8 stretch resumes with ticks", n, STRETCH - 1);
    endtask

    initial begin
        t_power_up();
        t_supply();
        t_manual();
        t_bounce();
        t_restart();
        t_no_tick();
        check(comp_bad == 0, "R7 outputs complementary every cycle", comp_bad, 0);
        summary();
        $finish;
    end

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end
endmodule